// File: doc/BRIEF.md
# Dynamic Bus Sizing Master

This block sits between an internal client and a 16-bit external data bus whose address lines are separate from its data lines. The client hands it one operand request: an address, an operand size of one, two or four bytes, a direction, and write data. The block splits that operand into as many external bus cycles as the addressed slave needs. Each cycle moves one or two bytes. It drives the address strobe, the data strobe, the read/write line, the address and a two-bit code giving the bytes of the operand still outstanding.

The slave closes every cycle with a two-line active-low acknowledge. The acknowledge also reports whether the slave port is one or two bytes wide. The block learns the port width again on each cycle and plans the next cycle from that answer, so the client never needs to know how wide the port is. Read bytes are collected most significant first and returned right-justified with a one-cycle done pulse. Write bytes are placed on the data lanes that both port widths can use.

Top module: `dbs_master`

## Requirements
- R1: While reset is held and on the first clock after it, `asN` and `dsN` are high (negated), and `busy` and `donePulse` are low.
- R2: The acknowledge `dsackN` is active low per line. `dsackN=2'b01` (only bit 1 low) reports a 16-bit port. `2'b10` (only bit 0 low) reports an 8-bit port. `2'b00` is treated as a 16-bit port. `2'b11` means no acknowledge. An 8-bit port moves exactly one byte per cycle.
- R3: Once both strobes are low, they stay low for as long as `dsackN` is `2'b11`. The block has no timeout.
- R4: On the clock after an acknowledge is sampled, `asN` is high. At least one clock with the strobes negated separates two cycles of the same operand.
- R5: `busSiz` gives the bytes still to move: 01 = one, 10 = two, 11 = three, 00 = four. `reqSize` uses the same code. After each acknowledged cycle, `busAddr` advances and the remaining count drops by the number of bytes moved. `busAddr` is stable while `asN` is low.
- R6: A four-byte operand at an even address takes two cycles on a 16-bit port and four cycles on an 8-bit port.
- R7: Any cycle that starts at an odd address moves one byte, even on a 16-bit port. A two-byte operand at an odd address therefore takes two cycles.
- R8: A one-byte read takes `dataIn[15:8]` from an 8-bit port or from an even address on a 16-bit port. It takes `dataIn[7:0]` from an odd address on a 16-bit port. A two-byte read takes `dataIn[15:8]` as the lower-addressed byte.
- R9: On writes all 16 lanes are driven. At an odd address, or when one byte remains, both `dataOut` lanes carry the current byte. Otherwise `dataOut[15:8]` carries the current byte and `dataOut[7:0]` carries the next one.
- R10: `donePulse` is high for exactly one clock. That clock follows the clock on which the last acknowledge is sampled. `rdData` then holds the read operand right-justified, with the lowest address in its most significant used byte.
- R11: On reads `dsN` falls with `asN`. On writes `dsN` falls one clock after `asN`.
- R12: `reqStart` is accepted only while `busy` is low. `busy` is high from the clock after acceptance until `donePulse`. A request made while busy starts no bus cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqStart | input | 1 | Request strobe from the client |
| reqAddr | input | ADDR_W | Operand start address |
| reqSize | input | 2 | Operand size code (same code as busSiz) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 32 | Write operand, right-justified |
| busy | output | 1 | An operand is in progress |
| donePulse | output | 1 | One-clock completion pulse |
| rdData | output | 32 | Read operand, right-justified |
| busAddr | output | ADDR_W | Bus address |
| busSiz | output | 2 | Bytes of the operand still outstanding |
| busRnW | output | 1 | 1 = read cycle, 0 = write cycle |
| asN | output | 1 | Address strobe, active low |
| dsN | output | 1 | Data strobe, active low |
| dataOut | output | 16 | Write data lanes |
| dataIn | input | 16 | Read data lanes |
| dsackN | input | 2 | Acknowledge with port width, active low |

## Verification
A bus cycle's address, size code and write lanes are due from the first clock on which both strobes are low. They are compared on the falling edge at which the bench slave asserts its acknowledge. The strobe release is due one clock after that acknowledge, and so is `donePulse` for the last cycle of an operand. The bench looks for both on the very next falling edge. The wait states the slave inserts move each of those points by exactly the number of clocks inserted. The bench counts those clocks and checks on each one that the strobes are still held, so every result is sampled in the single cycle the requirements fix for it.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  localparam int BUS_W = 16;
  localparam int OP_W  = 32;

  typedef struct packed {
    logic load;
    logic step;
  } ctlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ASRT,
    ST_DATA,
    ST_GAP
  } busState_t;

  function automatic logic ackSeen(input logic [1:0] ackN);
    return ackN != 2'b11;
  endfunction

  function automatic logic ackIsByte(input logic [1:0] ackN);
    return ackN == 2'b10;
  endfunction

endpackage

// File: rtl/dbs_ctrl.sv
module dbs_ctrl
  import dbs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqStart,
  input  logic        reqWrite,
  input  logic [1:0]  dsackN,
  input  logic        lastStep,
  output ctlStrobes_t ctl,
  output logic        asN,
  output logic        dsN,
  output logic        busRnW,
  output logic        busy,
  output logic        donePulse
);

  busState_t state, nextState;
  logic      rnwReg;

  always_comb begin
    nextState = state;
    ctl       = '0;
    case (state)
      ST_IDLE: begin
        if (reqStart) begin
          ctl.load  = 1'b1;
          nextState = ST_ASRT;
        end
      end
      ST_ASRT: begin
        if (rnwReg && ackSeen(dsackN)) begin
          ctl.step  = 1'b1;
          nextState = lastStep ? ST_IDLE : ST_GAP;
        end else begin
          nextState = ST_DATA;
        end
      end
      ST_DATA: begin
        if (ackSeen(dsackN)) begin
          ctl.step  = 1'b1;
          nextState = lastStep ? ST_IDLE : ST_GAP;
        end
      end
      default: nextState = ST_ASRT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      rnwReg    <= 1'b1;
      donePulse <= 1'b0;
    end else begin
      state     <= nextState;
      donePulse <= ctl.step && lastStep;
      if (ctl.load) rnwReg <= !reqWrite;
    end
  end

  assign asN    = !(state == ST_ASRT || state == ST_DATA);
  assign dsN    = !(state == ST_DATA || (state == ST_ASRT && rnwReg));
  assign busRnW = rnwReg;
  assign busy   = state != ST_IDLE;

  // R3: strobes held while no acknowledge is present
  assert_hold_until_ack_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!asN && !dsN && dsackN == 2'b11) |=> !asN);

  // R4: strobes released on the clock after a sampled acknowledge
  assert_release_after_ack_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!dsN && dsackN != 2'b11) |=> asN);

  // R11: data strobe only inside address strobe
  assert_ds_inside_as_R11: assert property (@(posedge clk) disable iff (!rstN)
    !dsN |-> !asN);

  // R11: write data strobe lags the address strobe
  assert_write_ds_delay_R11: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(asN) && !busRnW) |-> dsN);

  // R10: completion is a single-clock pulse
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

endmodule

// File: rtl/dbs_dpath.sv
module dbs_dpath
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [OP_W-1:0]   reqWdata,
  input  logic [1:0]        dsackN,
  input  logic [BUS_W-1:0]  dataIn,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSiz,
  output logic [BUS_W-1:0]  dataOut,
  output logic [OP_W-1:0]   rdData,
  output logic              lastStep
);

  localparam int LANE_W = BUS_W / 2;

  logic [ADDR_W-1:0] addrReg;
  logic [2:0]        remReg, accBytes, loadCount;
  logic [OP_W-1:0]   opReg, rdAcc;
  logic              port8, twoByte, dupLane;
  logic [LANE_W-1:0] laneByte;

  always_comb begin
    case (reqSize)
      2'b01:   loadCount = 3'd1;
      2'b10:   loadCount = 3'd2;
      2'b11:   loadCount = 3'd3;
      default: loadCount = 3'd4;
    endcase
  end

  assign port8    = ackIsByte(dsackN);
  assign twoByte  = !port8 && !addrReg[0] && remReg != 3'd1;
  assign accBytes = twoByte ? 3'd2 : 3'd1;
  assign lastStep = remReg == accBytes;
  assign laneByte = (port8 || !addrReg[0]) ? dataIn[BUS_W-1:LANE_W] : dataIn[LANE_W-1:0];
  assign dupLane  = addrReg[0] || remReg == 3'd1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      remReg  <= 3'd0;
      opReg   <= '0;
      rdAcc   <= '0;
    end else if (ctl.load) begin
      addrReg <= reqAddr;
      remReg  <= loadCount;
      opReg   <= reqWdata << {3'd4 - loadCount, 3'b000};
      rdAcc   <= '0;
    end else if (ctl.step) begin
      addrReg <= addrReg + ADDR_W'(accBytes);
      remReg  <= remReg - accBytes;
      if (twoByte) begin
        opReg <= opReg << BUS_W;
        rdAcc <= {rdAcc[OP_W-BUS_W-1:0], dataIn};
      end else begin
        opReg <= opReg << LANE_W;
        rdAcc <= {rdAcc[OP_W-LANE_W-1:0], laneByte};
      end
    end
  end

  assign busAddr = addrReg;
  assign busSiz  = remReg[1:0];
  assign dataOut = dupLane ? {opReg[OP_W-1 -: LANE_W], opReg[OP_W-1 -: LANE_W]}
                           : opReg[OP_W-1 -: BUS_W];
  assign rdData  = rdAcc;

  // R2: an 8-bit acknowledge advances the address by one byte
  assert_byte_port_advance_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && dsackN == 2'b10) |=> addrReg == $past(addrReg) + ADDR_W'(1));

  // R7: an odd-address cycle never moves two bytes
  assert_odd_single_byte_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && addrReg[0]) |=> remReg == $past(remReg) - 3'd1);

endmodule

// File: rtl/dbs_master.sv
module dbs_master
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqStart,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic [31:0]       reqWdata,
  output logic              busy,
  output logic              donePulse,
  output logic [31:0]       rdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSiz,
  output logic              busRnW,
  output logic              asN,
  output logic              dsN,
  output logic [15:0]       dataOut,
  input  logic [15:0]       dataIn,
  input  logic [1:0]        dsackN
);

  ctlStrobes_t ctl;
  logic        lastStep;

  dbs_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqStart  (reqStart),
    .reqWrite  (reqWrite),
    .dsackN    (dsackN),
    .lastStep  (lastStep),
    .ctl       (ctl),
    .asN       (asN),
    .dsN       (dsN),
    .busRnW    (busRnW),
    .busy      (busy),
    .donePulse (donePulse)
  );

  dbs_dpath #(.ADDR_W(ADDR_W)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqAddr  (reqAddr),
    .reqSize  (reqSize),
    .reqWdata (reqWdata),
    .dsackN   (dsackN),
    .dataIn   (dataIn),
    .busAddr  (busAddr),
    .busSiz   (busSiz),
    .dataOut  (dataOut),
    .rdData   (rdData),
    .lastStep (lastStep)
  );

  // R5: address held steady through a bus cycle
  assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!asN && $past(!asN)) |-> $stable(busAddr));

  // R9: odd-address writes repeat the byte on both lanes
  assert_odd_lane_copy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!asN && !busRnW && busAddr[0]) |-> dataOut[15:8] == dataOut[7:0]);

endmodule

// File: tb/dbs_master_tb_top.sv
module dbs_master_tb_top;

  localparam time CLK_PERIOD = 10;
  localparam int  ADDR_W     = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqStart = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [1:0]        reqSize = 2'b00;
  logic              reqWrite = 1'b0;
  logic [31:0]       reqWdata = '0;
  logic              busy, donePulse, busRnW, asN, dsN;
  logic [31:0]       rdData;
  logic [ADDR_W-1:0] busAddr;
  logic [1:0]        busSiz;
  logic [15:0]       dataOut;
  logic [15:0]       dataIn = '0;
  logic [1:0]        dsackN = 2'b11;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dbs_master #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .busy(busy), .donePulse(donePulse), .rdData(rdData),
    .busAddr(busAddr), .busSiz(busSiz), .busRnW(busRnW), .asN(asN),
    .dsN(dsN), .dataOut(dataOut), .dataIn(dataIn), .dsackN(dsackN)
  );

  typedef struct {
    logic [31:0] addr;
    logic [1:0]  siz;
    logic        rnw;
    logic [15:0] wd;
  } cyc_t;

  typedef struct {
    logic        isRead;
    logic [31:0] data;
    string       tag;
  } res_t;

  cyc_t expCyc[$];
  res_t expRes[$];

  int       nChecks = 0;
  int       nFail   = 0;
  logic [1:0] ackCode = 2'b01;
  int       waitStates = 0;
  bit       finished = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] memByte(input logic [31:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction

  function automatic logic [7:0] opByte(input logic [31:0] wd, input int n, input int j);
    return wd[8*(n-1-j) +: 8];
  endfunction

  // Slave model and cycle monitor
  int waitCnt = 0;
  bit prevAs = 1'b1, holdPending = 1'b0, relPending = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (relPending) begin
        check(asN == 1'b1, "R4 release after ack", {31'b0, asN}, 32'd1);
        relPending = 1'b0;
      end
      if (holdPending) begin
        check(asN == 1'b0, "R3 hold without ack", {31'b0, asN}, 32'd0);
        holdPending = 1'b0;
      end
      if (!asN && prevAs)
        check(dsN == !busRnW, "R11 data strobe timing", {31'b0, dsN}, {31'b0, !busRnW});
      if (!asN && !dsN && dsackN == 2'b11) begin
        if (waitCnt >= waitStates) begin
          if (expCyc.size() == 0) begin
            check(1'b0, "R12 unexpected bus cycle", busAddr, 32'hFFFF_FFFF);
          end else begin
            cyc_t e;
            e = expCyc.pop_front();
            check(busAddr == e.addr, "R5 address", busAddr, e.addr);
            check(busSiz == e.siz, "R5 size code", {30'b0, busSiz}, {30'b0, e.siz});
            check(busRnW == e.rnw, "R5 direction", {31'b0, busRnW}, {31'b0, e.rnw});
            if (!e.rnw)
              check(dataOut == e.wd, "R9 write lanes", {16'b0, dataOut}, {16'b0, e.wd});
          end
          if (ackCode == 2'b10)
            dataIn = {memByte(busAddr), 8'h3C};
          else
            dataIn = {memByte({busAddr[31:1], 1'b0}), memByte({busAddr[31:1], 1'b1})};
          dsackN = ackCode;
          relPending = 1'b1;
        end else begin
          waitCnt++;
          holdPending = 1'b1;
        end
      end else if (asN) begin
        dsackN  = 2'b11;
        waitCnt = 0;
      end
      prevAs = asN;
    end
  end

  // Result monitor
  always @(negedge clk) begin
    if (rstN && donePulse) begin
      if (expRes.size() == 0) begin
        check(1'b0, "R10 unexpected done", 32'd1, 32'd0);
      end else begin
        res_t r;
        r = expRes.pop_front();
        if (r.isRead)
          check(rdData == r.data, {r.tag, " read operand"}, rdData, r.data);
      end
    end
  end

  // Driver: computes the expected cycles and result, then issues the request
  task automatic doOp(input logic [31:0] a, input int n, input bit wr,
                      input logic [31:0] wd, input logic [1:0] ack, input int ws,
                      input bit poke, input string tag);
    int rem = n;
    int idx = 0;
    int t = 0;
    logic [31:0] cur = a;
    logic [31:0] rd = '0;
    bit port8 = (ack == 2'b10);
    res_t r;
    while (rem > 0) begin
      cyc_t c;
      int k;
      k = (port8 || cur[0] || rem == 1) ? 1 : 2;
      c.addr = cur;
      c.siz  = (rem == 4) ? 2'b00 : 2'(rem);
      c.rnw  = !wr;
      if (cur[0] || rem == 1) c.wd = {opByte(wd, n, idx), opByte(wd, n, idx)};
      else                    c.wd = {opByte(wd, n, idx), opByte(wd, n, idx + 1)};
      expCyc.push_back(c);
      if (k == 2) rd = {rd[15:0], memByte(cur), memByte(cur + 1)};
      else        rd = {rd[23:0], memByte(cur)};
      cur = cur + k;
      rem = rem - k;
      idx = idx + k;
    end
    r.isRead = !wr;
    r.data   = rd;
    r.tag    = tag;
    expRes.push_back(r);
    ackCode    = ack;
    waitStates = ws;
    @(negedge clk);
    reqStart = 1'b1;
    reqAddr  = a;
    reqSize  = (n == 4) ? 2'b00 : 2'(n);
    reqWrite = wr;
    reqWdata = wd;
    @(negedge clk);
    reqStart = 1'b0;
    check(busy == 1'b1, "R12 busy after accept", {31'b0, busy}, 32'd1);
    if (poke) begin
      repeat (3) @(negedge clk);
      reqStart = 1'b1;
      reqAddr  = 32'h0000_0500;
      reqWrite = !wr;
      reqSize  = 2'b01;
      @(negedge clk);
      reqStart = 1'b0;
    end
    while (!donePulse && t < 500) begin
      @(negedge clk);
      t++;
    end
    check(donePulse == 1'b1, {tag, " done pulse"}, {31'b0, donePulse}, 32'd1);
    check(expCyc.size() == 0, {tag, " cycle count R6"}, expCyc.size(), 32'd0);
    repeat (2) @(negedge clk);
    check(asN == 1'b1 && busy == 1'b0, "R12 idle after done", {30'b0, asN, busy}, 32'd2);
    expCyc.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(asN && dsN && !busy && !donePulse, "R1 reset state",
          {28'b0, asN, dsN, busy, donePulse}, 32'hC);
    rstN = 1'b1;
    @(negedge clk);
    check(asN && dsN && !busy && !donePulse, "R1 after reset",
          {28'b0, asN, dsN, busy, donePulse}, 32'hC);

    doOp(32'h0000_1000, 4, 1'b0, 32'h0, 2'b01, 0, 1'b0, "R6 long 16-bit");
    doOp(32'h0000_2000, 4, 1'b0, 32'h0, 2'b10, 1, 1'b0, "R2 long 8-bit");
    doOp(32'h0000_3003, 2, 1'b0, 32'h0, 2'b00, 0, 1'b0, "R7 odd word");
    doOp(32'h0000_4010, 1, 1'b0, 32'h0, 2'b01, 2, 1'b0, "R8 even byte 16");
    doOp(32'h0000_4011, 1, 1'b0, 32'h0, 2'b01, 0, 1'b0, "R8 odd byte 16");
    doOp(32'h0000_4013, 1, 1'b0, 32'h0, 2'b10, 0, 1'b0, "R8 odd byte 8");
    doOp(32'h0000_5001, 4, 1'b1, 32'hDEAD_BEEF, 2'b01, 2, 1'b0, "R9 odd long write");
    doOp(32'h0000_6000, 1, 1'b1, 32'h0000_005A, 2'b01, 0, 1'b0, "R9 even byte write");
    doOp(32'h0000_6100, 2, 1'b1, 32'h0000_C3D4, 2'b10, 0, 1'b0, "R9 word write 8-bit");
    doOp(32'h0000_7001, 4, 1'b0, 32'h0, 2'b10, 0, 1'b0, "R10 odd long 8-bit");
    doOp(32'h0000_7101, 2, 1'b0, 32'h0, 2'b01, 0, 1'b0, "R10 odd word 16");
    doOp(32'h0000_8000, 4, 1'b1, 32'h1234_5678, 2'b10, 1, 1'b1, "R12 busy ignore");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL R10 watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule